// File: doc/BRIEF.md
# Single-Frame Transmit Buffer with Host Control

This block sends one Ethernet-style frame at a time. A host fills a word buffer through a data port, one 32-bit word per write. It then launches the frame with a single write to a control register. That write carries the byte count and a start flag. The block emits the frame byte by byte on a valid/ready stream with a last marker. When configured to, it zero-pads short frames and appends a CRC-32. When the frame is finished, it clears the start flag and reports the outcome in the control register.

A completion cause bit records every finished or aborted frame. The interrupt line follows that cause only while its enable bit is set. The host polls the start flag or waits for the interrupt, reads back the outcome, and clears the cause. No descriptors and no queue are involved. The host must not launch a frame longer than the buffer holds (four bytes per word).

Register addresses on the 3-bit address: 0 data port (write only), 1 control, 2 configuration, 3 interrupt enable, 4 interrupt cause.

Top module: `tx_frame_buffer`

## Requirements
- R1: Words written to address 0 are stored in order. Byte i of the frame is byte (i mod 4) of word i/4, where byte 0 is bits 7:0, so the stream carries the least significant byte first. Only the first (length mod 4) bytes of the final word are sent, or all four when that value is 0.
- R2: A write to address 1 with bit 31 set launches the frame, and bits 11:0 of that write give the byte count. `tx_valid` is high only while bytes remain to be sent. A byte moves on a cycle where `tx_valid` and `tx_ready` are both high. `tx_last` marks the final byte.
- R3: Bit 31 of address 1 (start) reads 1 from the launch until the frame ends, and the hardware clears it at that point.
- R4: After a normal completion, bit 30 of address 1 (error) reads 0 and bits 11:0 read the total number of bytes sent on the stream, including padding and CRC.
- R5: Every completion or abort sets bit 0 of address 4 (cause). Writing 1 to that bit clears it. `irq` is high only while both the cause bit and bit 0 of address 3 (enable) are 1. Writing 0 to address 3 therefore masks the interrupt.
- R6: Configuration bit 1 (pad) enables padding. When it is set and the byte count is below 60, zero bytes follow the data until the body reaches 60 bytes.
- R7: Configuration bit 2 (crc) enables a CRC. When it is set, four CRC-32 bytes follow the body, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones, covers the body including padding, and is inverted at the end. The pad and crc bits are captured at launch.
- R8: While start reads 1, writes to the data port and to the control register have no effect.
- R9: Clearing configuration bit 0 (transmit enable) while a frame is in progress does the following: the stream stops, start clears, error reads 1, bits 11:0 give the number of bytes accepted before the abort, and the cause bit is set.
- R10: A launch whose total frame size is zero (byte count 0 with padding and CRC off) sends nothing and completes at once with error 1 and length 0.
- R11: After reset, all readable registers are 0, and both `tx_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Masked completion interrupt |

## Verification
The frame patterns are chosen so that each one tells a different rule apart:

- A 7-byte frame with a ragged last word checks the byte order and the partial-word rule.
- A 10-byte frame with padding and CRC checks the pad-then-CRC ordering.
- A 64-byte frame with only CRC checks the CRC without padding.
- A 61-byte frame with padding on confirms that frames at or above 60 bytes are left alone.

The sink's ready is driven from a pseudo-random sequence, so that stalls land on payload, pad and CRC bytes alike. Further cases cover the remaining rules:

- A fully stalled frame is used to show that data and control writes are ignored while busy.
- The frame sent after that one proves the buffer pointer was not disturbed.
- An abort partway through a frame, the zero-length launch, and interrupt masking with the enable bit cleared cover the remaining completion paths.

// File: rtl/tx_frame_buffer.sv
module tx_frame_buffer #(
  parameter int WORDS     = 512,
  parameter int LEN_W     = 12,
  parameter int MIN_FRAME = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int AW = $clog2(WORDS);
  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_CFG = 3'd2, A_IEN = 3'd3, A_CAUSE = 3'd4;
  localparam logic [31:0] POLY = 32'hEDB88320;
  localparam logic [LEN_W-1:0] MINB = LEN_W'(MIN_FRAME);

  logic [31:0] mem [WORDS];
  logic [AW:0] wptr;
  logic busy, err, en, pad_en, crc_en, pad_q, crc_q, cause, ien;
  logic [LEN_W-1:0] len, bcnt;
  logic [31:0] crc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'b0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  wire [LEN_W-1:0] body  = (pad_q && len < MINB) ? MINB : len;
  wire [LEN_W-1:0] total = body + (crc_q ? LEN_W'(4) : LEN_W'(0));
  wire             in_data = bcnt < len;
  wire             in_body = bcnt < body;
  wire [31:0]      word    = mem[bcnt[AW+1:2]];
  wire [1:0]       cidx    = bcnt[1:0] - body[1:0];
  wire [31:0]      crc_out = ~crc;
  wire [7:0]       d_byte  = 8'(word >> {bcnt[1:0], 3'b000});
  wire [7:0]       c_byte  = 8'(crc_out >> {cidx, 3'b000});

  assign tx_valid = busy & en & (total != '0);
  assign tx_data  = in_data ? d_byte : (in_body ? 8'h00 : c_byte);
  assign tx_last  = bcnt == total - LEN_W'(1);
  assign irq      = cause & ien;

  wire fire   = tx_valid & tx_ready;
  wire done   = fire & tx_last;
  wire abort  = busy & ~en;
  wire empty  = busy & en & (total == '0);
  wire push   = wr_en & (wr_addr == A_DATA) & ~busy & (wptr < (AW+1)'(WORDS));
  wire launch = wr_en & (wr_addr == A_CTRL) & ~busy;
  wire unused_bits = ^wr_data[30:LEN_W];

  always_ff @(posedge clk)
    if (push) mem[wptr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; busy <= 1'b0; err <= 1'b0; en <= 1'b0; pad_en <= 1'b0; crc_en <= 1'b0;
      pad_q <= 1'b0; crc_q <= 1'b0; cause <= 1'b0; ien <= 1'b0;
      len <= '0; bcnt <= '0; crc <= '1;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (launch) begin
        len <= wr_data[LEN_W-1:0]; err <= 1'b0; busy <= wr_data[31];
        bcnt <= '0; crc <= '1; pad_q <= pad_en; crc_q <= crc_en;
      end
      if (wr_en && wr_addr == A_CFG) {crc_en, pad_en, en} <= wr_data[2:0];
      if (wr_en && wr_addr == A_IEN) ien <= wr_data[0];
      if (wr_en && wr_addr == A_CAUSE && wr_data[0]) cause <= 1'b0;
      if (fire) begin
        bcnt <= bcnt + 1'b1;
        if (in_body) crc <= crc_step(crc, tx_data);
      end
      if (done)  begin busy <= 1'b0; len <= total; cause <= 1'b1; wptr <= '0; end
      if (abort) begin busy <= 1'b0; err <= 1'b1; len <= bcnt; cause <= 1'b1; wptr <= '0; end
      if (empty) begin busy <= 1'b0; err <= 1'b1; len <= '0; cause <= 1'b1; wptr <= '0; end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = {busy, err, {(30-LEN_W){1'b0}}, len};
      A_CFG:   rd_data = {29'b0, crc_en, pad_en, en};
      A_IEN:   rd_data = {31'b0, ien};
      A_CAUSE: rd_data = {31'b0, cause};
      default: rd_data = '0;
    endcase
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid);
  assert_hold_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || $stable(tx_data)));
  assert_cause_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (cause && !busy));
  assert_abort_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> (!busy && err && cause));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == A_DATA) |=> $stable(wptr));
  assert_pad_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last && pad_q) |-> (bcnt >= MINB - LEN_W'(1)));
endmodule

// File: tb/test_tx_frame_buffer.sv
module test_tx_frame_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic clk = 0, rst_n = 0, wr_en = 0, tx_ready = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, irq;

  tx_frame_buffer i_tx_frame_buffer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, popped = 0, exp_total = 0;
  bit armed = 0, stall = 0;
  byte unsigned q[$];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= stall ? 1'b0 : (lfsr[0] | lfsr[3]);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tx_valid === (armed && q.size() > 0), "R2 valid", 32'(tx_valid), 32'(armed && q.size() > 0));
    if (tx_valid && tx_ready && q.size() > 0) begin
      chk(tx_data === q[0], "R1/R6/R7 byte", 32'(tx_data), 32'(q[0]));
      chk(tx_last === (q.size() == 1), "R2 last", 32'(tx_last), 32'(q.size() == 1));
      void'(q.pop_front());
      popped++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a; #1 v = rd_data;
  endtask

  function automatic logic [31:0] word_of(int seed, int i);
    return 32'(seed) * 32'h9E3779B9 + 32'(i) * 32'h01010101 + 32'h5A;
  endfunction

  task automatic send(input int len, input bit pad, input bit crc, input int seed);
    byte unsigned body[$];
    logic [31:0] c;
    wr(3'd2, {29'b0, crc, pad, 1'b1});
    for (int i = 0; i < (len + 3) / 4; i++) wr(3'd0, word_of(seed, i));
    for (int i = 0; i < len; i++) body.push_back(8'(word_of(seed, i / 4) >> (8 * (i % 4))));
    if (pad) while (body.size() < 60) body.push_back(8'h00);
    q = body;
    if (crc) begin
      c = 32'hFFFFFFFF;
      foreach (body[j]) for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ body[j][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
      c = ~c;
      for (int k = 0; k < 4; k++) q.push_back(8'(c >> (8 * k)));
    end
    exp_total = q.size();
    popped = 0;
    wr(3'd1, {1'b1, 19'b0, 12'(len)});
    armed = 1;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    int n = 0;
    rd(3'd1, v);
    while (v[31] && n < 20000) begin @(posedge clk); #1 rd(3'd1, v); n++; end
    @(posedge clk); #1;
    chk(!v[31], {req, " start cleared"}, v[31], 0);
    armed = 0;
  endtask

  task automatic check_result(input string req, input bit exp_err, input int exp_len);
    logic [31:0] v;
    rd(3'd1, v);
    chk(v[30] == exp_err, {req, " error flag"}, v[30], exp_err);
    chk(v[11:0] == 12'(exp_len), {req, " length"}, v[11:0], exp_len);
    chk(q.size() == 0, {req, " all bytes sent"}, q.size(), 0);
  endtask

  task automatic clear_cause;
    wr(3'd4, 32'd1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    for (int a = 1; a < 5; a++) begin rd(3'(a), v); chk(v == 0, "R11 reset reg", v, 0); end
    chk(!irq && !tx_valid, "R11 reset outputs", {irq, tx_valid}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    wr(3'd3, 32'd1);

    send(7, 0, 0, 1);
    rd(3'd1, v);
    chk(v[31] == 1'b1, "R3 start reads 1 while sending", v[31], 1);
    wait_done("R3");
    check_result("R4 frame 7", 0, 7);
    chk(irq == 1'b1, "R5 irq on completion", irq, 1);
    clear_cause;
    chk(irq == 1'b0, "R5 irq cleared", irq, 0);

    send(10, 1, 1, 2);  wait_done("R6");  check_result("R6/R7 pad+crc", 0, 64);  clear_cause;
    send(64, 0, 1, 3);  wait_done("R7");  check_result("R7 crc only", 0, 68);    clear_cause;
    send(61, 1, 0, 4);  wait_done("R6");  check_result("R6 no pad at 61", 0, 61); clear_cause;

    stall = 1;
    send(13, 0, 0, 5);
    wr(3'd0, 32'hDEADBEEF);
    wr(3'd1, {1'b1, 19'b0, 12'd3});
    rd(3'd1, v);
    chk(v[31] && v[11:0] == 12'd13, "R8 ctrl write ignored", v, {1'b1, 19'b0, 12'd13});
    stall = 0;
    wait_done("R8");
    check_result("R8 frame unaffected", 0, 13);
    clear_cause;
    send(5, 0, 0, 6);   wait_done("R8");  check_result("R8 buffer pointer intact", 0, 5); clear_cause;

    wr(3'd3, 32'd0);
    send(4, 0, 0, 7);   wait_done("R5");  check_result("R1 full last word", 0, 4);
    rd(3'd4, v);
    chk(v[0] == 1'b1, "R5 cause set while masked", v[0], 1);
    chk(irq == 1'b0, "R5 irq masked", irq, 0);
    wr(3'd3, 32'd1);
    chk(irq == 1'b1, "R5 irq after enable", irq, 1);
    clear_cause;
    chk(irq == 1'b0, "R5 irq after clear", irq, 0);

    send(40, 0, 0, 8);
    repeat (12) @(posedge clk);
    #1 wr(3'd2, 32'd0);
    armed = 0;
    q.delete();
    repeat (3) @(posedge clk);
    #1 rd(3'd1, v);
    chk(!v[31] && v[30], "R9 abort flags", v[31:30], 2'b01);
    chk(v[11:0] == 12'(popped), "R9 bytes before abort", v[11:0], popped);
    chk(popped < 40, "R9 frame cut short", popped, 40);
    chk(irq == 1'b1, "R9 cause on abort", irq, 1);
    clear_cause;

    send(0, 0, 0, 9);
    repeat (3) @(posedge clk);
    #1 armed = 0;
    rd(3'd1, v);
    chk(!v[31] && v[30] && v[11:0] == 0, "R10 zero length", v, 32'h40000000);
    chk(irq == 1'b1, "R10 cause set", irq, 1);
    clear_cause;

    send(9, 1, 1, 10);  wait_done("R7");  check_result("R7 after abort", 0, 64);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule